// File: doc/BRIEF.md
# USB Low/Full-Speed Line Sampler

This block watches the two USB data lines through a fast sampling clock and turns them into a stream of bus symbols for a downstream decoder. Each clock, the synchronized line pair is classified as one of four bus states. The pair-to-state mapping depends on a speed-select input, because the two idle-level symbols swap meaning between low speed and full speed.

While the bus is idle, the block waits for the first K state. That edge marks the start of a packet. From it, the block lays a sampling grid: one sample per bit time, placed at the bit centre. The grid is built from a fixed-point clocks-per-bit value chosen by the speed mode, with an accumulator carrying the fractional part. Each sample emits the classified symbol, a valid strobe and the bit's index within the packet.

The downstream decoder owns packet framing. It pulses an end-of-packet input to send the sampler back to idle.

Top module: `usb_line_sampler`

## Requirements
- R1: Symbol codes are J=0, K=1, SE0=2, SE1=3. The line pair {dp,dm}=00 yields SE0 and 11 yields SE1, in both speed modes.
- R2: With `low_speed`=0, {dp,dm}=10 yields J and 01 yields K.
- R3: With `low_speed`=1, J and K are swapped: {dp,dm}=01 yields J and 10 yields K.
- R4: While idle, J, SE0 and SE1 never start a packet. When the synchronized pair changes to K, `sop` pulses for exactly one cycle. The pulse comes three clock edges after the line change: two synchronizer stages plus one register.
- R5: The value of `cpb_q` is `FS_CPB_Q` or `LS_CPB_Q`, in units of 1/256 clock, chosen by the speed mode at SOP. `sym_valid` for bit n is high exactly floor((cpb_q/2 + n*cpb_q)/256) cycles after the `sop` cycle. Bit 0 is the K that started the packet.
- R6: `bit_idx` carries n with the symbol of bit n. It restarts at 0 after every SOP.
- R7: A one-cycle `eop_done` pulse returns the block to idle. No `sym_valid` follows until the next SOP.
- R8: While idle, the lines are evaluated only when the synchronized pair changes. A pair that stays at K, or a mode switch that reinterprets an unchanged pair as K, starts no packet.
- R9: While a packet is being sampled, K states never raise `sop`.
- R10: After reset, `sop`, `sym_valid`, `sym` and `bit_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_speed | input | 1 | 1 selects low-speed symbol mapping and bit time |
| dp | input | 1 | D+ line, asynchronous |
| dm | input | 1 | D- line, asynchronous |
| eop_done | input | 1 | Pulse from the decoder: packet over, return to idle |
| sym | output | 2 | Classified symbol at the bit centre |
| sym_valid | output | 1 | One-cycle strobe per sampled bit |
| sop | output | 1 | One-cycle start-of-packet pulse |
| bit_idx | output | IDX_W | Index of the bit carried in `sym` |

## Verification
A fault in the fractional accumulator shows up as `sym_valid` arriving one cycle early or late against the computed offset. It usually appears first on a bit whose ideal position crosses a clock boundary, within a few bits of SOP. A wrong busy/idle state shows as either a spurious `sop` during a packet or symbols leaking out after `eop_done`. Both are visible on the first K or the first bit time after the fault. A swapped mapping or a stale index corrupts the very first symbol, since bit 0 must read K with index 0.

// File: rtl/usb_line_sampler.sv
module usb_line_sampler #(
  parameter int FRAC_W   = 8,
  parameter int CPB_W    = 16,
  parameter int IDX_W    = 8,
  parameter int FS_CPB_Q = 5333,
  parameter int LS_CPB_Q = 42667
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_speed,
  input  logic             dp,
  input  logic             dm,
  input  logic             eop_done,
  output logic [1:0]       sym,
  output logic             sym_valid,
  output logic             sop,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int ACC_W = CPB_W + 1;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1 << FRAC_W);
  localparam logic [1:0] S_J = 2'd0, S_K = 2'd1, S_SE0 = 2'd2, S_SE1 = 2'd3;

  logic [1:0]       s1, s2, prev;
  logic             prev_ok, busy;
  logic [ACC_W-1:0] acc;
  logic [CPB_W-1:0] cpb_r, cpb_sel;
  logic [IDX_W-1:0] nidx;
  logic [1:0]       cls;

  always_comb begin
    case (s2)
      2'b00:   cls = S_SE0;
      2'b11:   cls = S_SE1;
      2'b10:   cls = low_speed ? S_K : S_J;
      default: cls = low_speed ? S_J : S_K;
    endcase
  end

  assign cpb_sel = low_speed ? CPB_W'(LS_CPB_Q) : CPB_W'(FS_CPB_Q);

  wire sop_det = !busy && !eop_done && cls == S_K && (!prev_ok || s2 != prev);
  wire take    = busy && !eop_done && acc < ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 2'b00; s2 <= 2'b00; prev <= 2'b00; prev_ok <= 1'b0;
      busy <= 1'b0; acc <= '0; cpb_r <= '0; nidx <= '0;
      sym <= 2'b00; sym_valid <= 1'b0; sop <= 1'b0; bit_idx <= '0;
    end else begin
      s1 <= {dp, dm};
      s2 <= s1;
      prev <= s2;
      prev_ok <= 1'b1;
      sop <= sop_det;
      sym_valid <= take;
      if (eop_done) begin
        busy <= 1'b0;
      end else if (sop_det) begin
        busy  <= 1'b1;
        cpb_r <= cpb_sel;
        acc   <= ACC_W'(cpb_sel >> 1) - ONE;
        nidx  <= '0;
      end else if (busy) begin
        if (take) begin
          acc     <= acc + ACC_W'(cpb_r) - ONE;
          sym     <= cls;
          bit_idx <= nidx;
          nidx    <= nidx + 1'b1;
        end else begin
          acc <= acc - ONE;
        end
      end
    end
  end

  a_r4_sop_single: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> !sop);

  a_r9_no_sop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !sop);

  a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !sym_valid);

  a_r1_se0_map: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> ((sym == S_SE0) == ($past(s2) == 2'b00)));

  a_r2_fs_j: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !$past(low_speed) && $past(s2) == 2'b10) |-> sym == S_J);

  a_r6_idx_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> nidx == '0);
endmodule

// File: tb/usb_line_sampler_test.sv
module usb_line_sampler_test;
  localparam int FS = 1088;
  localparam int LS = 1920;

  logic clk = 0, rst_n = 0, low_speed = 0, dp = 1, dm = 0, eop_done = 0;
  logic [1:0] sym;
  logic sym_valid, sop;
  logic [7:0] bit_idx;

  always #2 clk = ~clk;

  usb_line_sampler #(.FS_CPB_Q(FS), .LS_CPB_Q(LS)) uut (
    .clk(clk), .rst_n(rst_n), .low_speed(low_speed), .dp(dp), .dm(dm),
    .eop_done(eop_done), .sym(sym), .sym_valid(sym_valid), .sop(sop),
    .bit_idx(bit_idx));

  int checks = 0, fails = 0, cyc = 0;
  int sop_cnt = 0, val_cnt = 0, sop_cyc = 0, exp_sop_cyc = -1;
  int q_sym[$], q_off[$], q_idx[$];
  logic [1:0] pkt[$];
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cls(input bit ls, input logic [1:0] p);
    case (p)
      2'b00:   return 2;
      2'b11:   return 3;
      2'b10:   return ls ? 1 : 0;
      default: return ls ? 0 : 1;
    endcase
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (sop) begin
      sop_cnt++;
      check(cyc == exp_sop_cyc, "R4/R8/R9 sop timing", cyc, exp_sop_cyc);
      exp_sop_cyc = -1;
      sop_cyc = cyc;
    end
    if (sym_valid) begin
      val_cnt++;
      if (q_sym.size() == 0) check(0, "R7 unexpected symbol", int'(sym), -1);
      else begin
        int es, eo, ei;
        es = q_sym.pop_front(); eo = q_off.pop_front(); ei = q_idx.pop_front();
        check(int'(sym) == es, "R1/R2/R3 symbol", int'(sym), es);
        check(cyc - sop_cyc == eo, "R5 sample offset", cyc - sop_cyc, eo);
        check(int'(bit_idx) == ei, "R6 bit index", int'(bit_idx), ei);
      end
    end
  end

  task automatic hold(input logic [1:0] p, input int n);
    {dp, dm} = p;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit ls, input int cpb);
    int len;
    low_speed = ls;
    for (int n = 0; n < pkt.size(); n++) begin
      q_sym.push_back(cls(ls, pkt[n]));
      q_off.push_back((cpb / 2 + n * cpb) >> 8);
      q_idx.push_back(n % 256);
    end
    exp_sop_cyc = cyc + 3;
    for (int n = 0; n < pkt.size(); n++) begin
      {dp, dm} = pkt[n];
      len = (((n + 1) * cpb) >> 8) - ((n * cpb) >> 8);
      repeat (len) @(negedge clk);
    end
    while (q_sym.size() != 0) @(negedge clk);
    eop_done = 1;
    @(negedge clk);
    eop_done = 0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(sop == 0 && sym_valid == 0 && sym == 0 && bit_idx == 0, "R10 reset state",
          int'({sop, sym_valid, sym, bit_idx}), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    hold(2'b00, 6); hold(2'b11, 6); hold(2'b10, 6);
    check(sop_cnt == 0, "R4 no sop from J/SE0/SE1", sop_cnt, 0);
    check(val_cnt == 0, "R7 no symbols while idle", val_cnt, 0);

    pkt = '{2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b01,
            2'b01, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00, 2'b00, 2'b10};
    send(0, FS);
    hold(2'b10, 30);
    check(sop_cnt == 1, "R9 single sop per packet", sop_cnt, 1);
    check(val_cnt == 16, "R7 no symbols after eop", val_cnt, 16);

    low_speed = 1;
    repeat (10) @(negedge clk);
    check(sop_cnt == 1, "R8 mode switch on unchanged pair", sop_cnt, 1);
    hold(2'b01, 6);
    pkt = '{2'b10, 2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10, 2'b10,
            2'b11, 2'b01, 2'b00, 2'b00, 2'b01};
    send(1, LS);
    hold(2'b01, 20);
    check(val_cnt == 29, "R3 low-speed symbol count", val_cnt, 29);

    low_speed = 0;
    hold(2'b10, 6);
    pkt = '{2'b01, 2'b10, 2'b01, 2'b01, 2'b11, 2'b01};
    send(0, FS);
    hold(2'b01, 40);
    check(sop_cnt == 3, "R8 held K starts no packet", sop_cnt, 3);
    check(val_cnt == 35, "R7 quiet after eop", val_cnt, 35);

    hold(2'b10, 6);
    pkt = '{2'b01, 2'b01, 2'b10, 2'b00, 2'b00, 2'b10};
    send(0, FS);
    hold(2'b10, 20);
    check(sop_cnt == 4, "R6 new packet restarts index", sop_cnt, 4);
    check(val_cnt == 41, "R5 all bits sampled", val_cnt, 41);
    summary();
  end
endmodule